// File: doc/BRIEF.md
# Monitor Channel Readout Sequencer

This block is the digital side of an on-die condition monitor. It steps through six sensor channels in a fixed order: die temperature, core supply, then external inputs 0 to 3, and back to temperature. It spends a fixed conversion time on each channel and then stores the channel's 10-bit sample in a read-only status word. Each stored result raises an end-of-conversion pulse, and the last enabled channel of a pass also raises an end-of-sequence pulse. The channel being converted is always visible on an output.

The conversion clock is not a separate clock. It is a tick derived from the register clock through a programmable ratio. The samples themselves come from a per-channel input bus, so the analog converter lies outside this block. A register-port master reads results and sets the ratio and the channel-enable set through a simple enable/write-enable/address/data bus with a one-cycle ready.

Top module: `mon_seq_top`

## Requirements
- R1: Channels are numbered 0 = temperature, 1 = core supply, 2..5 = external inputs 0..3. With all channels enabled, the current channel on `chan_id` runs 0,1,2,3,4,5 and then wraps to 0.
- R2: Every conversion lasts exactly 26 conversion ticks, counted from the start of the channel to the cycle in which its result is written.
- R3: A conversion tick occurs once every N register-clock cycles. N is the value in bits [7:0] of the control word at address 40h, and a value of 0 acts as 1. So consecutive results with all channels enabled are 26·N cycles apart. The reset value of N is 10.
- R4: Reading status address k (00h..05h) returns channel k's last result as {sample[9:0], 6'b000000}. Status addresses 06h..3Fh read 0.
- R5: A write to any address 00h..3Fh or 80h..FFh is ignored, and addresses 80h..FFh read 0. Only 40h (ratio) and 41h (enable set) are writable; other addresses in 42h..7Fh read 0.
- R6: `eoc` is high for exactly one cycle, the cycle after the result is written. `eos` is high together with `eoc` exactly when no enabled channel has a higher number than the finished one.
- R7: Bits [5:0] of address 41h enable channels by number (reset value 3Fh). The next channel is the next enabled channel above the current one, wrapping to the lowest enabled channel, and disabled channels cost no time. If the enable set is 0 when a conversion ends, the sequencer goes idle. When the set later becomes nonzero, it restarts at the lowest enabled channel on the next cycle. `chan_id` changes only when a result is written or on that restart.
- R8: An enable accepted while `reg_rdy` is low gives `reg_rdy` high for exactly the next cycle. An enable seen while `reg_rdy` is high is ignored. `reg_rdata` carries read data in the `reg_rdy` cycle and is 0 in every other cycle.
- R9: `busy` is high while a conversion is in progress and low during reset and while idle.
- R10: Reset is synchronous and active low. It sets `chan_id` to 0, clears all results, the ratio to 10 and the enable set to 3Fh, and drives `eoc`, `eos` and `reg_rdy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | 60 | Per-channel 10-bit samples, channel k at bits [10k+9:10k] |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rdy |
| reg_rdy | output | 1 | Access complete |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-sequence pulse |
| chan_id | output | 3 | Current channel number |

## Verification
The sequencer is run with all channels enabled at ratios 10, 2 and 0. The spacing of results then shows whether the divider and the 26-tick count are right, and whether 0 is treated as 1. Sparse enable sets (channels 2, 3 and 5, then only 4 and 5) show whether disabled channels are skipped without cost and whether `eos` follows the highest enabled channel. An empty set shows the idle path and the restart at the lowest channel. Writes to status and out-of-range addresses, back-to-back enables and a mid-run reset show whether ignored accesses leave state untouched and whether reset returns to temperature.

// File: rtl/mon_seq_pkg.sv
// Package: shared address map constants and region decode for the
// monitor channel readout sequencer. Assumes an 8-bit register address.
package mon_seq_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] RATIO_ADDR  = 8'h40;
    localparam logic [ADDR_W-1:0] ENABLE_ADDR = 8'h41;

    typedef enum logic [1:0] {
        REGION_STATUS = 2'd0,
        REGION_CTRL   = 2'd1,
        REGION_NONE   = 2'd2
    } reg_region_e;

    // Map an address to its region: 00-3F status, 40-7F control, rest none.
    function automatic reg_region_e region_of(input logic [ADDR_W-1:0] addr);
        if (addr[7:6] == 2'b00)
            return REGION_STATUS;
        else if (addr[7:6] == 2'b01)
            return REGION_CTRL;
        else
            return REGION_NONE;
    endfunction

endpackage

// File: rtl/mon_clk_div.sv
// Module: conversion tick generator. Produces a one-cycle tick every
// RATIO register-clock cycles (RATIO of 0 acts as 1). Held at phase zero
// while clear is high so that every conversion starts on a fresh period.
// Assumes ratio may change at any time; a shrunk ratio ticks at once.
module mon_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last_phase;

    // Purpose: highest phase value of one period.
    always_comb begin
        last_phase = (ratio == '0) ? '0 : ratio - 1'b1;
    end

    assign tick = !clear && (phase_q >= last_phase);

    // Purpose: advance the phase counter, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/mon_conv_seq.sv
// Module: channel sequencer. Walks the enabled channels in ascending
// number order with wrap, spends CONV_TICKS ticks on each, and reports
// the result write plus registered end-of-conversion/sequence pulses.
// Assumes tick is a single-cycle strobe and the enable mask is stable
// enough to be sampled at the end of a conversion.
module mon_conv_seq #(
    parameter int NUM_CH     = 6,
    parameter int CONV_TICKS = 26,
    parameter int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] en_mask,
    output logic              active,
    output logic [CH_W-1:0]   chan,
    output logic              res_we,
    output logic              eoc,
    output logic              eos
);

    localparam int CC_W = $clog2(CONV_TICKS);
    localparam logic [CC_W-1:0] CC_LAST = CC_W'(CONV_TICKS - 1);

    logic [CC_W-1:0] cc_q;
    logic [CH_W-1:0] chan_q;
    logic            active_q;
    logic            eoc_q;
    logic            eos_q;
    logic            above_found;
    logic [CH_W-1:0] above_ch;
    logic            any_found;
    logic [CH_W-1:0] lowest_ch;
    logic            done;

    // Purpose: find the lowest enabled channel and the next one above the current.
    always_comb begin
        above_found = 1'b0;
        above_ch    = '0;
        any_found   = 1'b0;
        lowest_ch   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (en_mask[i] && !any_found) begin
                any_found = 1'b1;
                lowest_ch = CH_W'(i);
            end
            if (en_mask[i] && (i > int'(chan_q)) && !above_found) begin
                above_found = 1'b1;
                above_ch    = CH_W'(i);
            end
        end
    end

    assign done = active_q && tick && (cc_q == CC_LAST);

    // Purpose: conversion counter, channel pointer and idle/active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            chan_q   <= '0;
            cc_q     <= '0;
        end else if (active_q) begin
            if (tick) begin
                if (cc_q == CC_LAST) begin
                    cc_q <= '0;
                    if (!any_found)
                        active_q <= 1'b0;
                    else
                        chan_q <= above_found ? above_ch : lowest_ch;
                end else begin
                    cc_q <= cc_q + 1'b1;
                end
            end
        end else if (any_found) begin
            active_q <= 1'b1;
            chan_q   <= lowest_ch;
            cc_q     <= '0;
        end
    end

    // Purpose: register the end-of-conversion and end-of-sequence pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_q <= 1'b0;
            eos_q <= 1'b0;
        end else begin
            eoc_q <= done;
            eos_q <= done && !above_found;
        end
    end

    assign active = active_q;
    assign chan   = chan_q;
    assign res_we = done;
    assign eoc    = eoc_q;
    assign eos    = eos_q;

endmodule

// File: rtl/mon_reg_port.sv
// Module: register port. Holds the read-only result words, the ratio and
// enable-set control words, and answers one access per enable with a
// ready one cycle later. Assumes the master waits for ready before the
// next enable; an enable during ready is dropped.
module mon_reg_port
    import mon_seq_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int RES_W    = 10,
    parameter int DATA_W   = 16,
    parameter int DIV_W    = 8,
    parameter int DIV_RST  = 10,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rdy,
    input  logic              res_we,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [RES_W-1:0]  res_val,
    output logic [DIV_W-1:0]  ratio,
    output logic [NUM_CH-1:0] en_mask
);

    localparam int PAD_W = DATA_W - RES_W;

    logic [RES_W-1:0]  result_q [NUM_CH];
    logic [DIV_W-1:0]  ratio_q;
    logic [NUM_CH-1:0] mask_q;
    logic              rdy_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_val;
    logic              accept;
    reg_region_e       region;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:DIV_W];
    assign accept = reg_en && !rdy_q;
    assign region = region_of(reg_addr);

    // Purpose: one result word per channel, written at end of conversion.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_result
        always_ff @(posedge clk) begin
            if (!rst_n)
                result_q[k] <= '0;
            else if (res_we && (res_ch == CH_W'(k)))
                result_q[k] <= res_val;
        end
    end

    // Purpose: select the read value for the addressed word.
    always_comb begin
        rd_val = '0;
        case (region)
            REGION_STATUS: begin
                if (reg_addr < ADDR_W'(NUM_CH))
                    rd_val = {result_q[reg_addr[CH_W-1:0]], {PAD_W{1'b0}}};
            end
            REGION_CTRL: begin
                if (reg_addr == RATIO_ADDR)
                    rd_val = DATA_W'(ratio_q);
                else if (reg_addr == ENABLE_ADDR)
                    rd_val = DATA_W'(mask_q);
            end
            default: rd_val = '0;
        endcase
    end

    // Purpose: control word writes; status and unmapped writes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= DIV_W'(DIV_RST);
            mask_q  <= '1;
        end else if (accept && reg_we) begin
            if (reg_addr == RATIO_ADDR)
                ratio_q <= reg_wdata[DIV_W-1:0];
            else if (reg_addr == ENABLE_ADDR)
                mask_q <= reg_wdata[NUM_CH-1:0];
        end
    end

    // Purpose: ready strobe and read data, zero outside the ready cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rdy_q   <= accept;
            rdata_q <= (accept && !reg_we) ? rd_val : '0;
        end
    end

    assign reg_rdy   = rdy_q;
    assign reg_rdata = rdata_q;
    assign ratio     = ratio_q;
    assign en_mask   = mask_q;

endmodule

// File: rtl/mon_seq_top.sv
// Module: top of the monitor channel readout sequencer. Connects the tick
// generator, the channel sequencer and the register port, and selects the
// sample of the current channel for storage. Assumes sample_in is stable
// around the end of each conversion.
module mon_seq_top
    import mon_seq_pkg::*;
#(
    parameter int NUM_CH     = 6,
    parameter int RES_W      = 10,
    parameter int DATA_W     = 16,
    parameter int DIV_W      = 8,
    parameter int DIV_RST    = 10,
    parameter int CONV_TICKS = 26,
    parameter int CH_W       = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*RES_W-1:0] sample_in,
    input  logic                    reg_en,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    reg_rdy,
    output logic                    busy,
    output logic                    eoc,
    output logic                    eos,
    output logic [CH_W-1:0]         chan_id
);

    logic              tick;
    logic              active;
    logic [CH_W-1:0]   chan;
    logic              res_we;
    logic [RES_W-1:0]  res_val;
    logic [DIV_W-1:0]  ratio;
    logic [NUM_CH-1:0] en_mask;

    mon_clk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!active),
        .ratio (ratio),
        .tick  (tick)
    );

    mon_conv_seq #(
        .NUM_CH     (NUM_CH),
        .CONV_TICKS (CONV_TICKS),
        .CH_W       (CH_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en_mask (en_mask),
        .active  (active),
        .chan    (chan),
        .res_we  (res_we),
        .eoc     (eoc),
        .eos     (eos)
    );

    // Purpose: pick the current channel's sample from the flat bus.
    always_comb begin
        res_val = sample_in[int'(chan)*RES_W +: RES_W];
    end

    mon_reg_port #(
        .NUM_CH  (NUM_CH),
        .RES_W   (RES_W),
        .DATA_W  (DATA_W),
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST),
        .CH_W    (CH_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_rdy   (reg_rdy),
        .res_we    (res_we),
        .res_ch    (chan),
        .res_val   (res_val),
        .ratio     (ratio),
        .en_mask   (en_mask)
    );

    assign busy    = active && rst_n;
    assign chan_id = chan;

endmodule

// File: rtl/mon_seq_chk.sv
// Module: protocol checker for the readout sequencer, bound to the top.
// Observes ports only and keeps its own spacing counter for results.
module mon_seq_chk #(
    parameter int NUM_CH     = 6,
    parameter int DATA_W     = 16,
    parameter int CONV_TICKS = 26,
    parameter int CH_W       = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              eoc,
    input logic              eos,
    input logic [CH_W-1:0]   chan_id,
    input logic              reg_en,
    input logic              reg_rdy,
    input logic [DATA_W-1:0] reg_rdata
);

    logic        seen_eoc;
    logic [31:0] gap;

    // Purpose: count cycles since the previous end-of-conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_eoc <= 1'b0;
            gap      <= '0;
        end else if (eoc) begin
            seen_eoc <= 1'b1;
            gap      <= '0;
        end else begin
            gap <= gap + 1;
        end
    end

    AST_EOC_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc); // R6
    AST_EOS_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> eoc); // R6
    AST_RDY_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_rdy) |=> reg_rdy); // R8
    AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdy |-> $past(reg_en && !reg_rdy)); // R8
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdy |-> (reg_rdata == '0)); // R8
    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan_id) < NUM_CH); // R1
    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !eoc) |-> $stable(chan_id)); // R7
    AST_EOC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && seen_eoc) |-> (gap >= 32'(CONV_TICKS - 1))); // R2

endmodule

bind mon_seq_top mon_seq_chk #(
    .NUM_CH     (NUM_CH),
    .DATA_W     (DATA_W),
    .CONV_TICKS (CONV_TICKS)
) u_chk (.*);

// File: tb/mon_seq_top_bench.sv
// Bench: behavioural cycle model compared with the design on every clock,
// plus directed checks for each requirement.
module mon_seq_top_bench;

    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [59:0] sample_in;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rdy;
    logic        busy;
    logic        eoc;
    logic        eos;
    logic [2:0]  chan_id;

    logic [9:0]  smp [NCH];

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NCH; k++) sample_in[k*10 +: 10] = smp[k];
    end

    mon_seq_top u_mon_seq_top (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rdy(reg_rdy),
        .busy(busy), .eoc(eoc), .eos(eos), .chan_id(chan_id)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_div, m_mask, m_chan, m_pre, m_cc;
    bit  m_active, m_eoc, m_eos, m_rdy;
    int  m_rdata;
    int  m_stat [NCH];

    function automatic int m_above(input int mask, input int ch);
        for (int i = ch + 1; i < NCH; i++) if (mask[i]) return i;
        return -1;
    endfunction

    function automatic int m_lowest(input int mask);
        for (int i = 0; i < NCH; i++) if (mask[i]) return i;
        return -1;
    endfunction

    function automatic int m_read(input int a);
        if (a < NCH) return m_stat[a] << 6;
        if (a == 'h40) return m_div;
        if (a == 'h41) return m_mask;
        return 0;
    endfunction

    always @(posedge clk) begin
        int  lim;
        bit  tk, acc, n_eoc, n_eos;
        int  rv, up;
        if (!rst_n) begin
            m_div = 10; m_mask = 'h3F; m_chan = 0; m_pre = 0; m_cc = 0;
            m_active = 1; m_eoc = 0; m_eos = 0; m_rdy = 0; m_rdata = 0;
            for (int k = 0; k < NCH; k++) m_stat[k] = 0;
        end else begin
            lim = (m_div == 0) ? 0 : m_div - 1;
            tk  = m_active && (m_pre >= lim);
            acc = reg_en && !m_rdy;
            rv  = (acc && !reg_we) ? m_read(int'(reg_addr)) : 0;
            n_eoc = 0; n_eos = 0;
            if (m_active) begin
                if (tk) begin
                    m_pre = 0;
                    if (m_cc == 25) begin
                        m_stat[m_chan] = int'(smp[m_chan]);
                        up = m_above(m_mask, m_chan);
                        n_eoc = 1;
                        n_eos = (up < 0);
                        m_cc = 0;
                        if (m_mask == 0) m_active = 0;
                        else m_chan = (up >= 0) ? up : m_lowest(m_mask);
                    end else m_cc++;
                end else m_pre++;
            end else begin
                m_pre = 0;
                if (m_mask != 0) begin
                    m_active = 1; m_chan = m_lowest(m_mask); m_cc = 0;
                end
            end
            if (acc && reg_we) begin
                if (reg_addr == 8'h40) m_div = int'(reg_wdata[7:0]);
                else if (reg_addr == 8'h41) m_mask = int'(reg_wdata[5:0]);
            end
            m_rdy = acc; m_rdata = rv; m_eoc = n_eoc; m_eos = n_eos;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            check(busy == (m_active && rst_n), "R9 busy", busy, m_active && rst_n);
            check(int'(chan_id) == m_chan, "R1 chan_id", chan_id, m_chan);
            check(eoc == m_eoc, "R6 eoc", eoc, m_eoc);
            check(eos == m_eos, "R6 eos", eos, m_eos);
            check(reg_rdy == m_rdy, "R8 reg_rdy", reg_rdy, m_rdy);
            check(int'(reg_rdata) == m_rdata, "R4 reg_rdata", reg_rdata, m_rdata);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic wait_eoc(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!eoc && n < 20000);
    endtask

    task automatic set_samples(input int base);
        for (int k = 0; k < NCH; k++) smp[k] = 10'(base + 37 * k);
    endtask

    initial begin
        logic [15:0] rd;
        int n;
        bit any_eoc;

        set_samples('h101);
        model_on = 1'b1;
        repeat (3) @(negedge clk);
        // R10 / R9: reset state
        check(busy == 1'b0, "R9 busy low in reset", busy, 0);
        check(chan_id == 3'd0 && !eoc && !eos && !reg_rdy, "R10 reset outputs", chan_id, 0);
        rst_n = 1'b1;

        // R1 / R2 / R3: default ratio 10
        wait_eoc(n);
        check(chan_id == 3'd1, "R1 after temperature comes core supply", chan_id, 1);
        wait_eoc(n);
        check(n == 260, "R3 spacing at ratio 10", n, 260);
        reg_read(8'h40, rd);
        check(rd == 16'd10, "R3 ratio reset value", rd, 10);

        // ratio 2
        reg_write(8'h40, 16'h0002);
        wait_eoc(n);
        wait_eoc(n);
        check(n == 52, "R2 26 ticks at ratio 2", n, 52);
        do wait_eoc(n); while (!eos);
        check(chan_id == 3'd0, "R1 wrap to temperature", chan_id, 0);
        for (int k = 0; k < NCH; k++) begin
            reg_read(8'(k), rd);
            check(rd == {smp[k], 6'b0}, "R4 status word", rd, {smp[k], 6'b0});
        end
        reg_read(8'h06, rd);
        check(rd == 16'h0, "R4 unused status reads zero", rd, 0);

        // R5: ignored writes
        reg_write(8'h00, 16'hFFFF);
        reg_write(8'h90, 16'h1234);
        reg_write(8'h45, 16'h00FF);
        reg_read(8'h00, rd);
        check(rd == {smp[0], 6'b0}, "R5 status write ignored", rd, {smp[0], 6'b0});
        reg_read(8'h90, rd);
        check(rd == 16'h0, "R5 high address reads zero", rd, 0);
        reg_read(8'h45, rd);
        check(rd == 16'h0, "R5 unmapped control reads zero", rd, 0);

        // R8: enable during ready is dropped
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'h41; reg_wdata = 16'h003F;
        @(negedge clk);
        check(reg_rdy == 1'b1, "R8 ready one cycle after enable", reg_rdy, 1);
        reg_wdata = 16'h0001;
        @(negedge clk);
        check(reg_rdy == 1'b0, "R8 enable during ready ignored", reg_rdy, 0);
        reg_en = 1'b0; reg_we = 1'b0;
        reg_read(8'h41, rd);
        check(rd == 16'h003F, "R8 dropped write left mask", rd, 'h3F);

        // R7: sparse set 2,3,5
        set_samples('h222);
        reg_write(8'h41, 16'h002C);
        wait_eoc(n);
        for (int j = 0; j < 6; j++) begin
            wait_eoc(n);
            check(n == 52, "R7 skip costs no time", n, 52);
            check(chan_id == 2 || chan_id == 3 || chan_id == 5, "R7 only enabled channels", chan_id, 2);
            if (eos) check(chan_id == 3'd2, "R6 eos after highest enabled", chan_id, 2);
        end

        // R3: ratio 0 acts as 1
        reg_write(8'h41, 16'h003F);
        reg_write(8'h40, 16'h0000);
        wait_eoc(n);
        wait_eoc(n);
        check(n == 26, "R3 ratio zero acts as one", n, 26);

        // R7 / R9: empty set goes idle, restart at lowest enabled
        reg_write(8'h41, 16'h0000);
        n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        check(busy == 1'b0, "R9 idle with empty set", busy, 0);
        any_eoc = 1'b0;
        repeat (60) begin @(negedge clk); any_eoc |= eoc; end
        check(any_eoc == 1'b0, "R7 no results while idle", any_eoc, 0);
        reg_write(8'h41, 16'h0030);
        @(negedge clk);
        check(busy == 1'b1 && chan_id == 3'd4, "R7 restart at lowest enabled", chan_id, 4);

        // R10: mid-run reset
        wait_eoc(n);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(chan_id == 3'd0 && busy == 1'b0, "R10 reset returns to temperature", chan_id, 0);
        rst_n = 1'b1;
        reg_read(8'h41, rd);
        check(rd == 16'h003F, "R10 enable set reset", rd, 'h3F);
        reg_read(8'h40, rd);
        check(rd == 16'd10, "R10 ratio reset", rd, 10);
        reg_read(8'h04, rd);
        check(rd == 16'h0, "R10 results cleared", rd, 0);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule